// File: doc/BRIEF.md
# HDLC Receive Deframer with Status Byte

This block turns a serial bit stream into HDLC frames. Bits arrive with a per-bit valid strobe. Cycles with the strobe low carry no bit. The block looks for the flag octet 0x7E and removes the zero bits that the sender stuffed in. It packs the remaining bits into bytes and writes each byte to a byte-wide write port that feeds a FIFO.

The frame check sequence bytes are not stripped. They go out like any other byte. One status byte follows the last byte of every frame, so a frame of n bytes (payload plus FCS) produces n+1 writes. The status byte reports one of four outcomes: good completion, CRC error, abort, or short frame. A long run of ones raises a separate idle output. Two frames may share a single flag between them.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Bits are packed least significant bit first: the first bit received after the opening flag becomes bit 0 of the first byte. Each completed byte is written (`fifo_wr` high for one cycle, value on `fifo_data`) in the cycle after its last bit is accepted.
- R2: A zero, six ones and a zero (0x7E) is a flag. Flags with no completed byte between them cause no write. This holds also for flags that share their boundary zero. The closing flag of one frame also opens the next frame.
- R3: Inside a frame, a zero that follows five consecutive ones is discarded and is not counted as data.
- R4: Both FCS bytes are written like payload bytes. Exactly one status byte is written as the next write after the last byte of a frame, so an n-byte frame gives n+1 writes.
- R5: The status byte is 0x01 (bit0, good end) when all of these hold: the frame has at least MIN_BYTES (4) bytes, it is a whole number of octets, and the CRC-16 residue is 0xF0B8. The CRC-16 is computed LSB first with the reflected polynomial 0x8408 and an initial value of 0xFFFF, over all written bytes including the FCS.
- R6: When the frame is long enough and whole but the residue differs, the status byte is 0x02 (bit1, CRC error).
- R7: The status byte is 0x08 (bit3, short) when the frame has fewer than MIN_BYTES bytes or its bit count is not a multiple of eight. Bits up to the closing flag are packed as data, so a trailing fragment together with the first flag bits can produce one extra byte before the status byte.
- R8: A seventh consecutive one inside a frame aborts the frame. If at least one byte was written, the status byte 0x04 (bit2) is written. Nothing more is written until the next flag.
- R9: `line_idle` rises in the cycle after the fifteenth consecutive accepted one. It falls in the cycle after the closing zero of the next flag.
- R10: Cycles with `ser_vld` low change nothing, whatever `ser_bit` carries.
- R11: After reset, `fifo_wr` and `line_idle` are low and the block is hunting for a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_vld | input | 1 | Bit strobe; `ser_bit` is taken only when high |
| ser_bit | input | 1 | Serial line bit |
| fifo_wr | output | 1 | One-cycle write strobe for data or status byte |
| fifo_data | output | 8 | Data byte or status byte |
| line_idle | output | 1 | Line idle indication |

## Verification
The bench builds the block with its default parameters. MIN_BYTES=4 makes a one-byte payload plus its FCS a short frame. The seven-ones abort and fifteen-ones idle limits can be reached within a single short run of ones. The CRC is the reflected CRC-16 with an initial value of all ones, so the bench can form a real FCS and a corrupted one, and check both residue outcomes. Bit gaps, and flag-shaped junk driven while the strobe is low, are mixed into frames so that the strobe gating is tested on live traffic.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   typedef enum logic [1:0] {
      BC_DATA  = 2'd0,
      BC_STUFF = 2'd1,
      BC_FLAG  = 2'd2,
      BC_ABORT = 2'd3
   } bit_class_e;

   localparam int STS_GOOD  = 0;
   localparam int STS_CRC   = 1;
   localparam int STS_ABORT = 2;
   localparam int STS_SHORT = 3;
endpackage

// File: rtl/hdlc_rx_line_mon.sv
module hdlc_rx_line_mon
   import hdlc_rx_pkg::*;
#(
   parameter int ABORT_ONES = 7,
   parameter int IDLE_ONES  = 15,
   parameter int STUFF_ONES = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_vld,
   input  logic       bit_in,
   output bit_class_e cls,
   output logic       idle
);
   localparam int ONES_W = $clog2(IDLE_ONES + 1);
   localparam logic [ONES_W-1:0] RUN_STUFF = ONES_W'(STUFF_ONES);
   localparam logic [ONES_W-1:0] RUN_FLAG  = ONES_W'(STUFF_ONES + 1);
   localparam logic [ONES_W-1:0] RUN_ABORT = ONES_W'(ABORT_ONES - 1);
   localparam logic [ONES_W-1:0] RUN_IDLE  = ONES_W'(IDLE_ONES - 1);
   localparam logic [ONES_W-1:0] RUN_SAT   = ONES_W'(IDLE_ONES);

   logic [ONES_W-1:0] ones_q;

   // classify the bit now on the line from the run of ones before it
   always_comb begin
      cls = BC_DATA;
      if (bit_in) begin
         if (ones_q == RUN_ABORT) cls = BC_ABORT;
      end else if (ones_q == RUN_STUFF) begin
         cls = BC_STUFF;
      end else if (ones_q == RUN_FLAG) begin
         cls = BC_FLAG;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= '0;
         idle   <= 1'b0;
      end else if (bit_vld) begin
         if (bit_in) begin
            if (ones_q != RUN_SAT) ones_q <= ones_q + 1'b1;
            if (ones_q == RUN_IDLE) idle <= 1'b1;
         end else begin
            ones_q <= '0;
            if (cls == BC_FLAG) idle <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
   parameter int              W       = 16,
   parameter logic [W-1:0]    POLY    = 16'h1021,
   parameter bit              REFLECT = 1'b1
) (
   input  logic [W-1:0] crc_in,
   input  logic [7:0]   byte_in,
   output logic [W-1:0] crc_out
);
   function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   localparam logic [W-1:0] POLY_REV = mirror(POLY);

   generate
      if (REFLECT) begin : g_lsb_first
         always_comb begin
            logic [W-1:0] c;
            logic         fb;
            c  = crc_in;
            fb = 1'b0;
            for (int i = 0; i < 8; i++) begin
               fb = c[0] ^ byte_in[i];
               c  = {1'b0, c[W-1:1]} ^ (fb ? POLY_REV : '0);
            end
            crc_out = c;
         end
      end else begin : g_msb_first
         always_comb begin
            logic [W-1:0] c;
            logic         fb;
            c  = crc_in;
            fb = 1'b0;
            for (int i = 7; i >= 0; i--) begin
               fb = c[W-1] ^ byte_in[i];
               c  = {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
            end
            crc_out = c;
         end
      end
   endgenerate
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int                MIN_BYTES   = 4,
   parameter int                ABORT_ONES  = 7,
   parameter int                IDLE_ONES   = 15,
   parameter int                CRC_W       = 16,
   parameter logic [CRC_W-1:0]  CRC_POLY    = 16'h1021,
   parameter logic [CRC_W-1:0]  CRC_INIT    = 16'hFFFF,
   parameter logic [CRC_W-1:0]  CRC_GOOD    = 16'hF0B8,
   parameter bit                CRC_REFLECT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_vld,
   input  logic       ser_bit,
   output logic       fifo_wr,
   output logic [7:0] fifo_data,
   output logic       line_idle
);
   localparam int STUFF_ONES = 5;
   localparam int CNT_W      = $clog2(MIN_BYTES + 1);
   localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_BYTES);

   generate
      if (ABORT_ONES <= STUFF_ONES + 1) begin : g_bad_abort
         $error("ABORT_ONES must exceed the flag run of ones");
      end
      if (IDLE_ONES < ABORT_ONES) begin : g_bad_idle
         $error("IDLE_ONES must not be below ABORT_ONES");
      end
      if (MIN_BYTES < 1) begin : g_bad_min
         $error("MIN_BYTES must be at least one");
      end
      if (CRC_W < 8) begin : g_bad_crc
         $error("CRC_W must be at least eight");
      end
   endgenerate

   bit_class_e       line_cls;
   logic             in_frame_q;
   logic [7:0]       sh_q;
   logic [2:0]       bitcnt_q;
   logic [CNT_W-1:0] bytecnt_q;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_next;
   logic [7:0]       byte_next;
   logic [7:0]       sts_word;
   logic             wr_sts_q;
   logic             push;

   hdlc_rx_line_mon #(
      .ABORT_ONES (ABORT_ONES),
      .IDLE_ONES  (IDLE_ONES),
      .STUFF_ONES (STUFF_ONES)
   ) line_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (ser_vld),
      .bit_in  (ser_bit),
      .cls     (line_cls),
      .idle    (line_idle)
   );

   assign byte_next = {ser_bit, sh_q[7:1]};
   assign push      = ser_vld && in_frame_q && (line_cls == BC_DATA);

   hdlc_rx_crc #(
      .W       (CRC_W),
      .POLY    (CRC_POLY),
      .REFLECT (CRC_REFLECT)
   ) crc_i (
      .crc_in  (crc_q),
      .byte_in (byte_next),
      .crc_out (crc_next)
   );

   // outcome of the frame that the current flag or abort closes
   always_comb begin
      sts_word = '0;
      if (line_cls == BC_ABORT)
         sts_word[STS_ABORT] = 1'b1;
      else if (bytecnt_q < MIN_CNT || bitcnt_q != 3'd7)
         sts_word[STS_SHORT] = 1'b1;
      else if (crc_q == CRC_GOOD)
         sts_word[STS_GOOD] = 1'b1;
      else
         sts_word[STS_CRC] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         sh_q       <= '0;
         bitcnt_q   <= '0;
         bytecnt_q  <= '0;
         crc_q      <= CRC_INIT;
         fifo_wr    <= 1'b0;
         fifo_data  <= '0;
         wr_sts_q   <= 1'b0;
      end else begin
         fifo_wr  <= 1'b0;
         wr_sts_q <= 1'b0;
         if (ser_vld && line_cls == BC_FLAG) begin
            if (in_frame_q && bytecnt_q != '0) begin
               fifo_wr   <= 1'b1;
               fifo_data <= sts_word;
               wr_sts_q  <= 1'b1;
            end
            in_frame_q <= 1'b1;
            bitcnt_q   <= '0;
            bytecnt_q  <= '0;
            crc_q      <= CRC_INIT;
         end else if (ser_vld && in_frame_q && line_cls == BC_ABORT) begin
            if (bytecnt_q != '0) begin
               fifo_wr   <= 1'b1;
               fifo_data <= sts_word;
               wr_sts_q  <= 1'b1;
            end
            in_frame_q <= 1'b0;
         end else if (push) begin
            sh_q     <= byte_next;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (bitcnt_q == 3'd7) begin
               fifo_wr   <= 1'b1;
               fifo_data <= byte_next;
               crc_q     <= crc_next;
               if (bytecnt_q != MIN_CNT) bytecnt_q <= bytecnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
   import hdlc_rx_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       ser_vld,
   input logic       ser_bit,
   input logic       fifo_wr,
   input logic [7:0] fifo_data,
   input logic       line_idle,
   input logic       is_sts,
   input logic       frame_active,
   input logic       has_bytes,
   input bit_class_e cls
);
   // R10: every write traces back to an accepted bit
   p_write_needs_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $past(ser_vld));

   // R5: a status byte carries exactly one outcome bit in the low nibble
   p_status_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && is_sts) |-> (fifo_data[7:4] == 4'h0 && $countones(fifo_data[3:0]) == 1));

   // R8: abort inside a frame with bytes yields the abort code next
   p_abort_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_vld && frame_active && cls == BC_ABORT && has_bytes) |=> (fifo_wr && fifo_data == 8'h04));

   // R4: a closing flag after bytes yields a status write next
   p_close_writes_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_vld && frame_active && cls == BC_FLAG && has_bytes) |=> (fifo_wr && is_sts));

   // R9: a flag clears idle
   p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_vld && cls == BC_FLAG) |=> !line_idle);

   // R9: idle only rises on an accepted one
   p_idle_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_idle) |-> $past(ser_vld && ser_bit));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ser_vld      (ser_vld),
   .ser_bit      (ser_bit),
   .fifo_wr      (fifo_wr),
   .fifo_data    (fifo_data),
   .line_idle    (line_idle),
   .is_sts       (wr_sts_q),
   .frame_active (in_frame_q),
   .has_bytes    (bytecnt_q != '0),
   .cls          (line_cls)
);

// File: tb/hdlc_rx_deframer_tb_top.sv
module hdlc_rx_deframer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_vld = 1'b0;
   logic       ser_bit = 1'b0;
   logic       fifo_wr;
   logic [7:0] fifo_data;
   logic       line_idle;

   always #5 clk = ~clk;

   hdlc_rx_deframer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_vld   (ser_vld),
      .ser_bit   (ser_bit),
      .fifo_wr   (fifo_wr),
      .fifo_data (fifo_data),
      .line_idle (line_idle)
   );

   int          n_chk  = 0;
   int          n_fail = 0;
   int          ones   = 0;
   int          gapc   = 0;
   logic [7:0]  exp_q[$];
   string       tag_q[$];
   logic [7:0]  cur[$];
   logic        done = 1'b0;

   task automatic check(input logic ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && fifo_wr) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected write", int'(fifo_data), 0);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(fifo_data == e, t, int'(fifo_data), int'(e));
         end
      end
   end

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
         else             r = r >> 1;
      end
      return r;
   endfunction

   task automatic expect_b(input logic [7:0] v, input string t);
      exp_q.push_back(v);
      tag_q.push_back(t);
   endtask

   // one accepted bit, with a strobe gap every third bit carrying junk
   task automatic send_bit(input logic b);
      ser_vld = 1'b1;
      ser_bit = b;
      @(negedge clk);
      gapc++;
      if (gapc % 3 == 0) begin
         ser_vld = 1'b0;
         ser_bit = ~b;
         @(negedge clk);
      end
      ser_vld = 1'b0;
   endtask

   task automatic data_bit(input logic b);
      send_bit(b);
      if (b) begin
         ones++;
         if (ones == 5) begin
            send_bit(1'b0);
            ones = 0;
         end
      end else begin
         ones = 0;
      end
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) data_bit(v[i]);
   endtask

   task automatic send_flag();
      send_bit(1'b0);
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      send_bit(1'b0);
      ones = 0;
   endtask

   // R10: flag- and abort-shaped junk while the strobe is low
   task automatic junk_gap();
      logic [14:0] pat;
      pat = 15'b111111101111110;
      for (int i = 0; i < 15; i++) begin
         ser_vld = 1'b0;
         ser_bit = pat[i];
         @(negedge clk);
      end
   endtask

   // mode 0: good FCS, 1: corrupted FCS; pushes bytes and status
   task automatic send_frame(input int mode, input logic junk);
      logic [15:0] c;
      logic [15:0] fcs;
      logic [15:0] res;
      logic [7:0]  all[$];
      c = 16'hFFFF;
      all = cur;
      foreach (cur[i]) c = crc_upd(c, cur[i]);
      fcs = ~c;
      if (mode == 1) fcs = fcs ^ 16'h0101;
      all.push_back(fcs[7:0]);
      all.push_back(fcs[15:8]);
      res = 16'hFFFF;
      foreach (all[i]) begin
         res = crc_upd(res, all[i]);
         expect_b(all[i], "R1 R4 data byte");
      end
      if (all.size() < 4)          expect_b(8'h08, "R7 short status");
      else if (res == 16'hF0B8)    expect_b(8'h01, "R5 good status");
      else                         expect_b(8'h02, "R6 crc status");
      foreach (all[i]) begin
         send_byte(all[i]);
         if (junk && i == 1) junk_gap();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check(fifo_wr == 1'b0, "R11 reset write", int'(fifo_wr), 0);
      check(line_idle == 1'b0, "R11 reset idle", int'(line_idle), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: fill flags, then flags sharing their boundary zero
      send_flag();
      send_flag();
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < 6; i++) send_bit(1'b1);
         send_bit(1'b0);
      end
      check(line_idle == 1'b0, "R9 idle low under flags", int'(line_idle), 0);

      // R1 R4 R5: good frame
      cur = '{8'h01, 8'h02, 8'h03};
      send_frame(0, 1'b0);
      send_flag();

      // R3: stuffing-heavy payload, shared flag, then corrupted FCS (R6) with junk (R10)
      cur = '{8'hFF, 8'h7E, 8'h3F, 8'hFC};
      send_frame(0, 1'b0);
      send_flag();
      cur = '{8'hA5, 8'h5A};
      send_frame(1, 1'b1);
      send_flag();

      // R7: one payload byte plus FCS is short
      cur = '{8'h42};
      send_frame(0, 1'b1);
      send_flag();

      // R7: five bytes then three zero bits; fragment plus flag head packs 0xF0
      foreach (cur[i]) cur.delete(i);
      for (int i = 1; i <= 5; i++) begin
         expect_b(8'(i * 16), "R1 R4 raw byte");
         send_byte(8'(i * 16));
      end
      expect_b(8'hF0, "R7 fragment byte");
      expect_b(8'h08, "R7 non-octet status");
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      send_flag();

      // R8 R9: abort after three bytes, run of seventeen ones
      for (int i = 1; i <= 3; i++) begin
         expect_b(8'(i * 17), "R1 R4 pre-abort byte");
         send_byte(8'(i * 17));
      end
      expect_b(8'h04, "R8 abort status");
      for (int i = 0; i < 13; i++) send_bit(1'b1);
      check(line_idle == 1'b0, "R9 idle before fifteen", int'(line_idle), 0);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      check(line_idle == 1'b1, "R9 idle after run", int'(line_idle), 1);
      junk_gap();
      check(line_idle == 1'b1, "R10 idle held in gap", int'(line_idle), 1);
      send_flag();
      check(line_idle == 1'b0, "R9 idle cleared by flag", int'(line_idle), 0);

      // recovery after abort
      cur = '{8'h99, 8'h88};
      send_frame(0, 1'b0);
      send_flag();

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule